// File: doc/BRIEF.md
# Reset Cause and NMI Control Register

This block is an 8-bit control and status register on an internal register bus. Read back, it tells software what kind of reset last occurred (hard or soft), whether the reset line to the expansion bus and the wireless module is currently driven, and which source raised a pending non-maskable interrupt. Written, it can ask the reset sequencer for a hard or soft reset. It can also raise or withdraw NMI requests for two consumers: a debugger interface and a storage interface.

A separate I/O-trap pulse can also raise the debugger NMI. It leaves its own flag set so that the interrupt handler can tell a trap from a software request. NMI-flag writes are dropped while some NMI master is already active. Writes that arrive through the display coprocessor's port may set NMI flags but never clear them. The reset-cause bits are kept apart from the NMI state, so a synchronous clear from the reset sequencer wipes the NMI flags but leaves the cause readable after a soft reset.

Top module: `reset_nmi_ctl`

## Requirements
- R1: Read bit 1 reads 1 when the last reset was hard and read bit 0 reads 1 when it was soft. Exactly one of the two bits is set at all times. After power-on reset the register reads 8'h02 and all request outputs are low.
- R2: A write with bit 1 high drives `hard_rst_req` high for exactly the one cycle after the write strobe and sets the cause to hard. A write with only bit 0 high does the same with `soft_rst_req` and the soft cause. A write with both bits high gives a hard request only.
- R3: Read bit 7 equals `exp_rst_active` in the same cycle.
- R4: Read bits 6:5 are always zero, whatever is written to them.
- R5: Writing 1 to bit 3 sets read bit 3 and `nmi_dbg_req`. Writing 1 to bit 2 sets read bit 2 and `nmi_stor_req`. On the main port, writing 0 to either bit clears it.
- R6: A pulse on `trap_pulse` sets read bit 4. `nmi_dbg_req` is high while read bit 3 or read bit 4 is set. A main-port write of 0 to bit 4 clears the flag, and a write of 1 to bit 4 has no effect.
- R7: While `nmi_busy` is high, writes leave read bits 4:2 unchanged. Reset requests in the same write still take effect. A trap pulse still sets bit 4.
- R8: When `wr_coproc` is high, a write may set bits 3:2, but zero bits in the write leave read bits 4:2 unchanged.
- R9: A trap pulse in the same cycle as a write that sets bit 3 leaves both bit 3 and bit 4 set. A trap pulse in the same cycle as a write of 0 to bit 4 leaves bit 4 set.
- R10: A cycle with `sys_clr` high clears read bits 4:2 and leaves read bits 1:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_clr | input | 1 | Synchronous clear of NMI state from the reset sequencer |
| wr_en | input | 1 | Register write strobe |
| wr_coproc | input | 1 | The write comes from the display coprocessor port |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| exp_rst_active | input | 1 | Reset line to the expansion bus is asserted |
| nmi_busy | input | 1 | Some NMI master is active |
| trap_pulse | input | 1 | Single-cycle I/O-trap event |
| hard_rst_req | output | 1 | Single-cycle hard reset request |
| soft_rst_req | output | 1 | Single-cycle soft reset request |
| nmi_dbg_req | output | 1 | NMI request to the debugger interface |
| nmi_stor_req | output | 1 | NMI request to the storage interface |

## Verification
The I/O-trap event and a register write to the NMI bits can land in the same cycle. The bench provokes this by raising `trap_pulse` during the write-strobe cycle, once with a write that sets bit 3 and once with a write that clears bit 4. It then judges the outcome from read bits 4:3 and `nmi_dbg_req` in the following cycle, where both flags must be set. A reset request combined with a busy-blocked flag write is also checked: the reset output must pulse while the flags stay put.

// File: rtl/rnc_pkg.sv
package rnc_pkg;
   // Field positions decoded by software
   localparam int BIT_SOFT  = 0;
   localparam int BIT_HARD  = 1;
   localparam int BIT_TRAP  = 4;
   localparam int BIT_EXP   = 7;
   localparam int NUM_CH    = 2;
   // Channel 0 is the debugger NMI, channel 1 the storage NMI
   localparam int CH_BIT [NUM_CH] = '{3, 2};

   typedef enum logic [1:0] {
      CAUSE_SOFT = 2'b01,
      CAUSE_HARD = 2'b10
   } cause_e;
endpackage

// File: rtl/rnc_flag.sv
module rnc_flag #(
   parameter bit WR_SET = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic wr_coproc,
   input  logic busy,
   input  logic ext_set,
   output logic flag
);
   logic nxt;

   always_comb begin
      nxt = flag;
      if (wr_en && !busy) begin
         if (wr_bit) begin
            if (WR_SET) nxt = 1'b1;
         end else if (!wr_coproc) begin
            nxt = 1'b0;
         end
      end
      if (ext_set) nxt = 1'b1;
      if (clr)     nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) flag <= 1'b0;
      else        flag <= nxt;
   end

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !clr && !ext_set) |=> $stable(flag));
   // R8
   coproc_noclear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_coproc && flag && !clr) |=> flag);
   // R9
   ext_set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ext_set && !clr) |=> flag);
   // R10
   clr_chk: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> !flag);
endmodule

// File: rtl/rnc_rst_req.sv
module rnc_rst_req
   import rnc_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       wr_en,
   input  logic       wr_hard,
   input  logic       wr_soft,
   output logic       hard_req,
   output logic       soft_req,
   output logic [1:0] cause
);
   logic want_hard, want_soft;

   always_comb begin
      want_hard = wr_en && wr_hard;
      want_soft = wr_en && wr_soft && !wr_hard;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hard_req <= 1'b0;
         soft_req <= 1'b0;
         cause    <= CAUSE_HARD;
      end else begin
         hard_req <= want_hard;
         soft_req <= want_soft;
         if (want_hard)      cause <= CAUSE_HARD;
         else if (want_soft) cause <= CAUSE_SOFT;
      end
   end

   // R1
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
      $countones(cause) == 1);
   // R2
   req_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(hard_req && soft_req));
   // R2
   hard_issue_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_hard) |=> (hard_req && cause == CAUSE_HARD));
   // R2
   soft_issue_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_soft && !wr_hard) |=> (soft_req && cause == CAUSE_SOFT));
endmodule

// File: rtl/reset_nmi_ctl.sv
module reset_nmi_ctl
   import rnc_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit TRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_clr,
   input  logic              wr_en,
   input  logic              wr_coproc,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              exp_rst_active,
   input  logic              nmi_busy,
   input  logic              trap_pulse,
   output logic              hard_rst_req,
   output logic              soft_rst_req,
   output logic              nmi_dbg_req,
   output logic              nmi_stor_req
);
   localparam int TOP_BIT = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("reset_nmi_ctl: DATA_W must be 8");
   end
   if (TOP_BIT != BIT_EXP) begin : g_bad_top
      $error("reset_nmi_ctl: top bit must carry the expansion reset state");
   end

   logic [1:0]        cause;
   logic [NUM_CH-1:0] ch_flag;
   logic              trap_flag;
   logic              unused_bits;

   assign unused_bits = ^{wr_data[6:5], wr_data[TOP_BIT]};

   rnc_rst_req u_rst (
      .clk      (clk),
      .por_n    (por_n),
      .wr_en    (wr_en),
      .wr_hard  (wr_data[BIT_HARD]),
      .wr_soft  (wr_data[BIT_SOFT]),
      .hard_req (hard_rst_req),
      .soft_req (soft_rst_req),
      .cause    (cause)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      rnc_flag #(.WR_SET(1'b1)) u_flag (
         .clk       (clk),
         .por_n     (por_n),
         .clr       (sys_clr),
         .wr_en     (wr_en),
         .wr_bit    (wr_data[CH_BIT[g]]),
         .wr_coproc (wr_coproc),
         .busy      (nmi_busy),
         .ext_set   (1'b0),
         .flag      (ch_flag[g])
      );
   end

   if (TRAP_EN) begin : g_trap
      rnc_flag #(.WR_SET(1'b0)) u_trap (
         .clk       (clk),
         .por_n     (por_n),
         .clr       (sys_clr),
         .wr_en     (wr_en),
         .wr_bit    (wr_data[BIT_TRAP]),
         .wr_coproc (wr_coproc),
         .busy      (nmi_busy),
         .ext_set   (trap_pulse),
         .flag      (trap_flag)
      );
   end else begin : g_no_trap
      logic unused_trap;
      assign unused_trap = trap_pulse ^ wr_data[BIT_TRAP];
      assign trap_flag   = 1'b0;
   end

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_EXP]  = exp_rst_active;
      rd_data[BIT_TRAP] = trap_flag;
      rd_data[BIT_HARD] = cause[1];
      rd_data[BIT_SOFT] = cause[0];
      for (int c = 0; c < NUM_CH; c++) rd_data[CH_BIT[c]] = ch_flag[c];
   end

   assign nmi_dbg_req  = ch_flag[0] | trap_flag;
   assign nmi_stor_req = ch_flag[1];

   // R10
   cause_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sys_clr && !wr_en) |=> $stable(cause));
endmodule

// File: tb/sim_reset_nmi_ctl.sv
module sim_reset_nmi_ctl;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_clr = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_coproc = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       exp_rst_active = 1'b0;
   logic       nmi_busy = 1'b0;
   logic       trap_pulse = 1'b0;
   logic       hard_rst_req, soft_rst_req, nmi_dbg_req, nmi_stor_req;

   int applied = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   reset_nmi_ctl u0 (
      .clk(clk), .por_n(por_n), .sys_clr(sys_clr), .wr_en(wr_en),
      .wr_coproc(wr_coproc), .wr_data(wr_data), .rd_data(rd_data),
      .exp_rst_active(exp_rst_active), .nmi_busy(nmi_busy),
      .trap_pulse(trap_pulse), .hard_rst_req(hard_rst_req),
      .soft_rst_req(soft_rst_req), .nmi_dbg_req(nmi_dbg_req),
      .nmi_stor_req(nmi_stor_req)
   );

   // {coproc, busy, trap, wdata[7:0], rd[4:0], hard, soft, dbg, stor}
   localparam int NV = 15;
   localparam logic [19:0] VEC [NV] = '{
      {3'b000, 8'h08, 5'b01010, 4'b0010},  // R5 set dbg
      {3'b000, 8'h0C, 5'b01110, 4'b0011},  // R5 set both
      {3'b000, 8'h04, 5'b00110, 4'b0001},  // R5 clear dbg
      {3'b010, 8'h00, 5'b00110, 4'b0001},  // R7 busy blocks clear
      {3'b100, 8'h08, 5'b01110, 4'b0011},  // R8 coproc sets, no clear
      {3'b100, 8'h00, 5'b01110, 4'b0011},  // R8 coproc zeros ignored
      {3'b000, 8'h0D, 5'b01101, 4'b0111},  // R2 soft request
      {3'b000, 8'h0F, 5'b01110, 4'b1011},  // R2 hard wins
      {3'b001, 8'h0C, 5'b11110, 4'b0011},  // R9 trap beats clear
      {3'b000, 8'h1C, 5'b11110, 4'b0011},  // R6 write 1 to bit4 keeps
      {3'b010, 8'h01, 5'b11101, 4'b0111},  // R7 busy, soft still issued
      {3'b000, 8'h08, 5'b01001, 4'b0010},  // R6 clear trap
      {3'b001, 8'h00, 5'b10001, 4'b0010},  // R6 trap drives dbg
      {3'b100, 8'h00, 5'b10001, 4'b0010},  // R8 coproc cannot clear trap
      {3'b000, 8'h70, 5'b10001, 4'b0010}   // R4 reserved bits written
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      applied++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset rd", {24'h0, rd_data}, 32'h02);
      check("R1 reset outs", {28'h0, hard_rst_req, soft_rst_req, nmi_dbg_req, nmi_stor_req}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         wr_coproc  = VEC[i][19];
         nmi_busy   = VEC[i][18];
         trap_pulse = VEC[i][17];
         wr_data    = VEC[i][16:9];
         wr_en      = 1'b1;
         @(negedge clk);
         wr_en = 1'b0; wr_coproc = 1'b0; nmi_busy = 1'b0; trap_pulse = 1'b0;
         check("R5/R6/R7/R8/R9/R2 vector", {23'h0, rd_data[4:0], hard_rst_req,
               soft_rst_req, nmi_dbg_req, nmi_stor_req}, {23'h0, VEC[i][8:0]});
         check("R4 reserved/R3 top", {29'h0, rd_data[7:5]}, 32'h0);
      end
      // state now: cause soft, trap set, channels clear
      // R3 expansion reset reflected
      exp_rst_active = 1'b1; #1;
      check("R3 high", {31'h0, rd_data[7]}, 32'h1);
      exp_rst_active = 1'b0; #1;
      check("R3 low", {31'h0, rd_data[7]}, 32'h0);
      @(negedge clk);
      // R10 sync clear keeps cause
      sys_clr = 1'b1;
      @(negedge clk);
      sys_clr = 1'b0;
      check("R10 clear", {24'h0, rd_data}, 32'h01);
      check("R10 dbg low", {31'h0, nmi_dbg_req}, 32'h0);
      // R9 trap with write setting bit 3
      wr_data = 8'h08; wr_en = 1'b1; trap_pulse = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; trap_pulse = 1'b0;
      check("R9 both kept", {24'h0, rd_data}, 32'h19);
      check("R9 dbg", {31'h0, nmi_dbg_req}, 32'h1);
      // R2 pulse length
      wr_data = 8'h1A; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 hard pulse", {30'h0, hard_rst_req, soft_rst_req}, 32'h2);
      check("R2 cause hard", {24'h0, rd_data}, 32'h1A);
      @(negedge clk);
      check("R2 pulse ends", {30'h0, hard_rst_req, soft_rst_req}, 32'h0);
      // R7 trap still sets while busy
      sys_clr = 1'b1;
      @(negedge clk);
      sys_clr = 1'b0;
      check("R10 clear after hard", {24'h0, rd_data}, 32'h02);
      nmi_busy = 1'b1; trap_pulse = 1'b1;
      @(negedge clk);
      nmi_busy = 1'b0; trap_pulse = 1'b0;
      check("R7 trap while busy", {24'h0, rd_data}, 32'h12);
      check("R6 dbg from trap", {31'h0, nmi_dbg_req}, 32'h1);
      finish_run();
   end
endmodule